// File: doc/BRIEF.md
# Glitchless Two-Source Clock Switch

This block picks one of two free-running clocks and passes it to a pair of clock outputs. When the selection changes, it moves from one source to the other without cutting a pulse short. First, the path of the old source is closed on a falling edge of that old clock. The output then rests low. After that, the path of the new source is opened on a falling edge of the new clock. Each source has its own leg with its own synchronizers. A leg opens only after it has seen that the other leg's gate is closed.

If the old source has died, the normal handshake can never finish. A force input covers this case. It clears the leg of the source that is no longer selected at once, without waiting for edges, so the new leg can open.

Each of the two outputs has its own output stage. All stages share three controls: an asynchronous enable, a level that a disabled output drives, and a power-down that takes priority and holds the output low.

Top module: `gcs_top`

## Requirements
- R1: With `sel` = 1 and the switch settled, every clock output equals `clk_a`. With `sel` = 0 it equals `clk_b`.
- R2: After `sel` changes, the output starts its parked low interval within three periods of the old clock.
- R3: The parked low interval lasts no longer than three periods of the new clock. After it, the output follows the new clock.
- R4: The two source gates are never open at the same time. During switchovers, no high or low pulse at an output is shorter than the shorter half period of the two sources.
- R5: If the old source has stopped, a plain change of `sel` leaves the output low. Raising `force_sel` then completes the change without any edge of the stopped clock, and the switch stays on the new source after `force_sel` falls.
- R6: With `out_en` = 0 and `pwr_dn` = 0, every output drives `park_lvl` asynchronously.
- R7: With `pwr_dn` = 1, every output is low, whatever `out_en` and `park_lvl` are.
- R8: While `rst_n` is low, both gates are closed and the outputs are low. After release, only the selected source is passed.
- R9: All outputs carry the same waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Source clock passed when `sel` = 1 |
| clk_b | input | 1 | Source clock passed when `sel` = 0 |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Source choice, asynchronous to both clocks |
| force_sel | input | 1 | Clears the leg of the unselected source at once |
| out_en | input | 1 | Asynchronous output enable, shared by all outputs |
| park_lvl | input | 1 | Level driven by a disabled output |
| pwr_dn | input | 1 | Forces all outputs low, overrides `out_en` |
| clk_out | output | NUM_OUT | Switched clock outputs |

## Verification
Suppose a gate flop or synchronizer holds a wrong value. If both gates are open at once, the output shows the OR of two clocks within one source cycle, and short pulses appear. If a gate is stuck closed, the parked low never ends, and the long low exceeds the three-cycle bound at the next switchover. If a gate moves while its clock is high, a shortened high pulse appears on that same cycle. The bench therefore measures the narrowest pulses and the longest low around every switchover, at three frequency ratios.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  // Minimum synchronizer depth for a crossing into a source leg
  localparam int unsigned GCS_SYNC_MIN = 2;

  // Shared controls of one output stage
  typedef struct packed {
    logic en;    // 1: pass the switched clock
    logic park;  // level while disabled
    logic pd;    // power-down, overrides en
  } gcs_octl_t;
endpackage

// File: rtl/gcs_leg.sv
// One source leg: reset synchronizer, request synchronizer and a gate
// flop that moves only on the falling edge of its own clock.
module gcs_leg #(
  parameter int unsigned SYNC_STAGES = gcs_pkg::GCS_SYNC_MIN
) (
  input  logic clk_src,
  input  logic clr_n,
  input  logic want,
  input  logic peer_on,
  output logic gate_on,
  output logic clk_gated
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [1:0]      rst_q, rst_d;
  logic            rdy;
  logic            req;
  logic [LAST:0]   sync_q, sync_d;
  logic            gate_q, gate_d;

  // reset release, synchronous to clk_src
  always_comb rst_d = {rst_q[0], 1'b1};
  always_ff @(posedge clk_src or negedge clr_n) begin
    if (!clr_n) rst_q <= '0;
    else        rst_q <= rst_d;
  end
  assign rdy = rst_q[1];

  // request: wanted and the peer gate confirmed closed
  assign req = want & ~peer_on;

  always_comb begin
    sync_d = sync_q;
    if (rdy) sync_d = {sync_q[LAST-1:0], req};
  end
  always_ff @(posedge clk_src or negedge clr_n) begin
    if (!clr_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  // gate moves only while clk_src is low
  always_comb gate_d = sync_q[LAST];
  always_ff @(negedge clk_src or negedge clr_n) begin
    if (!clr_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  assign gate_on   = gate_q;
  assign clk_gated = clk_src & gate_q;
endmodule

// File: rtl/gcs_out_ctl.sv
// Output stage: power-down first, then enable, else the park level.
module gcs_out_ctl
  import gcs_pkg::*;
(
  input  logic      clk_in,
  input  gcs_octl_t ctl,
  output logic      clk_o
);
  always_comb begin
    if (ctl.pd)       clk_o = 1'b0;
    else if (!ctl.en) clk_o = ctl.park;
    else              clk_o = clk_in;
  end
endmodule

// File: rtl/gcs_top.sv
module gcs_top
  import gcs_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 2,
  parameter int unsigned SYNC_STAGES = GCS_SYNC_MIN
) (
  input  logic               clk_a,
  input  logic               clk_b,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               force_sel,
  input  logic               out_en,
  input  logic               park_lvl,
  input  logic               pwr_dn,
  output logic [NUM_OUT-1:0] clk_out
);
  localparam int unsigned NUM_LEG = 2;

  logic [NUM_LEG-1:0] leg_clk, leg_want, leg_clr_n, gate_on, leg_out;
  logic               clk_sw;
  gcs_octl_t          octl;

  // leg 0 carries clk_a (sel = 1), leg 1 carries clk_b (sel = 0)
  assign leg_clk  = {clk_b, clk_a};
  assign leg_want = {~sel, sel};

  for (genvar g = 0; g < NUM_LEG; g++) begin : g_leg
    // a forced switch clears the unwanted leg without waiting for its clock
    assign leg_clr_n[g] = rst_n & ~(force_sel & ~leg_want[g]);

    gcs_leg #(.SYNC_STAGES(SYNC_STAGES)) u_leg (
      .clk_src  (leg_clk[g]),
      .clr_n    (leg_clr_n[g]),
      .want     (leg_want[g]),
      .peer_on  (gate_on[NUM_LEG-1-g]),
      .gate_on  (gate_on[g]),
      .clk_gated(leg_out[g])
    );
  end

  assign clk_sw = |leg_out;

  assign octl.en   = out_en;
  assign octl.park = park_lvl;
  assign octl.pd   = pwr_dn;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    gcs_out_ctl u_octl (
      .clk_in(clk_sw),
      .ctl   (octl),
      .clk_o (clk_out[o])
    );
  end
endmodule

// File: rtl/gcs_chk.sv
module gcs_chk #(
  parameter int unsigned NUM_OUT = 2
) (
  input logic               clk_a,
  input logic               clk_b,
  input logic               rst_n,
  input logic               sel,
  input logic               force_sel,
  input logic               out_en,
  input logic               park_lvl,
  input logic               pwr_dn,
  input logic [1:0]         gate_on,
  input logic [NUM_OUT-1:0] clk_out
);
  // R4: gates mutually exclusive, seen from either clock
  a_r4_excl_on_a: assert property (@(posedge clk_a) disable iff (!rst_n)
    !(gate_on[0] && gate_on[1]));
  a_r4_excl_on_b: assert property (@(posedge clk_b) disable iff (!rst_n)
    !(gate_on[0] && gate_on[1]));

  // R5: forced switch keeps the unselected gate closed
  a_r5_force_a_closed: assert property (@(posedge clk_b) disable iff (!rst_n)
    (force_sel && !sel) |-> !gate_on[0]);
  a_r5_force_b_closed: assert property (@(posedge clk_a) disable iff (!rst_n)
    (force_sel && sel) |-> !gate_on[1]);

  // R6: disabled outputs drive the park level
  a_r6_park_level: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!out_en && !pwr_dn) |-> (clk_out == {NUM_OUT{park_lvl}}));

  // R7: power-down holds all outputs low
  a_r7_power_down: assert property (@(posedge clk_b) disable iff (!rst_n)
    pwr_dn |-> (clk_out == '0));
endmodule

bind gcs_top gcs_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk_a    (clk_a),
  .clk_b    (clk_b),
  .rst_n    (rst_n),
  .sel      (sel),
  .force_sel(force_sel),
  .out_en   (out_en),
  .park_lvl (park_lvl),
  .pwr_dn   (pwr_dn),
  .gate_on  (gate_on),
  .clk_out  (clk_out)
);

// File: tb/tb_gcs_top.sv
`timescale 1ns/1ps
module tb_gcs_top;
  logic       clk_a, clk_b, rst_n, sel, force_sel, out_en, park_lvl, pwr_dn;
  logic [1:0] clk_out;

  real ha = 2.5;   // 200 MHz clk_a
  real hb = 3.5;
  bit  run_a = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  gcs_top #(.NUM_OUT(2)) dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .sel(sel),
    .force_sel(force_sel), .out_en(out_en), .park_lvl(park_lvl),
    .pwr_dn(pwr_dn), .clk_out(clk_out)
  );

  initial begin
    clk_a = 1'b0;
    forever begin #(ha); if (run_a) clk_a = ~clk_a; end
  end
  initial begin
    clk_b = 1'b0;
    #1.3;
    forever begin #(hb); clk_b = ~clk_b; end
  end

  // pulse monitor on output 0
  bit      meas = 1'b0, seen_r = 1'b0, seen_f = 1'b0;
  realtime t_rise, t_fall, min_hi, min_lo, max_lo, max_lo_start;
  always @(posedge clk_out[0]) begin
    if (meas && seen_f) begin
      if ($realtime - t_fall < min_lo) min_lo = $realtime - t_fall;
      if ($realtime - t_fall > max_lo) begin
        max_lo = $realtime - t_fall; max_lo_start = t_fall;
      end
    end
    if (meas) seen_r = 1'b1;
    t_rise = $realtime;
  end
  always @(negedge clk_out[0]) begin
    if (meas && seen_r && ($realtime - t_rise < min_hi)) min_hi = $realtime - t_rise;
    if (meas) seen_f = 1'b1;
    t_fall = $realtime;
  end

  task automatic chk_v(string req, string what, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_t(string req, string what, bit ok, real act, real lim);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f limit %0.3f", req, what, act, lim);
    end
  endtask

  function automatic real rmin(real x, real y); return (x < y) ? x : y; endfunction
  function automatic real rmax(real x, real y); return (x > y) ? x : y; endfunction

  // R1 / R9: both outputs track the selected source
  task automatic t_follow(string tag);
    for (int k = 0; k < 3; k++) begin
      if (sel) begin
        @(posedge clk_a); #(ha/2); chk_v("R1/R9", {tag, " high"}, clk_out, 2'b11);
        @(negedge clk_a); #(ha/2); chk_v("R1/R9", {tag, " low"},  clk_out, 2'b00);
      end else begin
        @(posedge clk_b); #(hb/2); chk_v("R1/R9", {tag, " high"}, clk_out, 2'b11);
        @(negedge clk_b); #(hb/2); chk_v("R1/R9", {tag, " low"},  clk_out, 2'b00);
      end
    end
  endtask

  // R8: reset state and the first source after release
  task automatic t_reset();
    rst_n = 1'b0; sel = 1'b1; force_sel = 1'b0;
    out_en = 1'b1; park_lvl = 1'b0; pwr_dn = 1'b0;
    repeat (3) @(posedge clk_a);
    #(ha/2); chk_v("R8", "output in reset, clk_a high", clk_out, 2'b00);
    #3.1 rst_n = 1'b1;
    repeat (10) @(posedge clk_a);
    t_follow("R8 after reset");
  endtask

  // R2 R3 R4: one switchover, bounds measured at the output
  task automatic t_switch(real new_hb);
    real t_old, t_new, ts, lim;
    hb = new_hb;
    repeat (4) @(posedge clk_b);
    t_old = sel ? 2*ha : 2*hb;
    t_new = sel ? 2*hb : 2*ha;
    min_hi = 1.0e9; min_lo = 1.0e9; max_lo = 0.0; max_lo_start = 0.0;
    seen_r = 1'b0; seen_f = 1'b0; meas = 1'b1;
    #(2*t_old + 0.37);
    ts = $realtime;
    sel = ~sel;
    #(30*rmax(t_old, t_new));
    meas = 1'b0;
    chk_t("R2", "park start after select change", (max_lo_start - ts) <= 3*t_old + 0.01,
          max_lo_start - ts, 3*t_old);
    chk_t("R3", "parked low length", (max_lo <= 3*t_new + 0.01) && (max_lo > 0.0),
          max_lo, 3*t_new);
    lim = rmin(ha, hb) - 0.01;
    chk_t("R4", "narrowest high pulse", min_hi >= lim, min_hi, lim);
    chk_t("R4", "narrowest low pulse",  min_lo >= lim, min_lo, lim);
    t_follow("R3 new source");
  endtask

  // R5: dead old source
  task automatic t_force();
    hb = 3.5;
    if (!sel) begin sel = 1'b1; #(40*2*hb); end
    @(negedge clk_a); run_a = 1'b0;
    #(3*2*hb);
    sel = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #(2*2*hb + 0.3);
      chk_v("R5", "no switch while old source dead", clk_out, 2'b00);
    end
    force_sel = 1'b1;
    #(10*2*hb);
    t_follow("R5 forced");
    force_sel = 1'b0;
    #(4*2*hb);
    t_follow("R5 after force release");
    run_a = 1'b1;
    #(10*2*ha);
    sel = 1'b1;
    #(40*2*hb);
    t_follow("R5 back to restarted source");
  endtask

  // R6: asynchronous disable and park level
  task automatic t_enable();
    out_en = 1'b0; park_lvl = 1'b1;
    #0.2 chk_v("R6", "park high", clk_out, 2'b11);
    #(ha) chk_v("R6", "park high later", clk_out, 2'b11);
    park_lvl = 1'b0;
    #0.2 chk_v("R6", "park low", clk_out, 2'b00);
    #(3*ha) chk_v("R6", "park low later", clk_out, 2'b00);
    out_en = 1'b1;
    #0.2;
    t_follow("R6 re-enabled");
  endtask

  // R7: power-down overrides enable and park level
  task automatic t_pwrdn();
    pwr_dn = 1'b1;
    @(posedge clk_a); #(ha/2);
    chk_v("R7", "power-down while enabled", clk_out, 2'b00);
    out_en = 1'b0; park_lvl = 1'b1;
    #0.2 chk_v("R7", "power-down over park high", clk_out, 2'b00);
    pwr_dn = 1'b0;
    #0.2 chk_v("R6", "park high after power-up", clk_out, 2'b11);
    out_en = 1'b1; park_lvl = 1'b0;
    #0.2;
    t_follow("R7 after power-up");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_switch(2.5);   // equal rates, offset phase
    t_switch(2.5);
    t_switch(7.0);   // new source slower
    t_switch(7.0);
    t_switch(1.6);   // new source faster
    t_switch(1.6);
    t_force();
    t_enable();
    t_pwrdn();
    finish_run();
  end

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule